// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Armed Empty Flag

This block is the transmit half of an asynchronous serial port, seen by a processor through a small register port. A byte written by software lands in a one-byte holding buffer; from there it moves into a frame shifter, which drives the serial line with one start bit, eight data bits and one stop bit. One shifter step is taken on each pulse of an external baud tick. While the shifter is busy, the holding buffer lets software queue the next byte, so frames can go out back to back.

The buffer-empty flag describes the holding buffer only, never the shifter. A data write only fills the buffer if it comes after a status read that saw the flag at 1. A data write without that armed read leaves the flag at 1 and sends nothing. When the shifter is idle and the transmitter is enabled, a freshly written byte passes straight on, so the flag is low for a single cycle. An interrupt request follows the flag while its enable bit is set. Software clears that enable bit after its last byte to stop the requests. A second flag reports that the line has gone fully quiet.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset the control register reads 0, status reads 0xC0 (buffer empty and line quiet), `txd` is 1 and `irq` is 0.
- R2: A data write that is not preceded by an armed status read leaves the empty flag at 1, and the byte is never transmitted.
- R3: A status read (address 1) that sees the empty flag at 1 arms the block. The next data write (address 2) stores the byte and clears the empty flag (status bit 7) at the clock edge that takes the write.
- R4: With the transmitter enabled (control bit 0) and the shifter idle, a stored byte moves into the shifter on the next edge. The empty flag returns to 1 on that edge, and `txd` drops to the start bit on the same edge.
- R5: With the transmitter disabled, a stored byte stays in the buffer, the empty flag stays 0 and `txd` stays 1. Setting the enable bit starts the transfer.
- R6: `irq` is 1 exactly when the empty flag is 1 and the interrupt enable (control bit 1) is 1. Clearing the enable drops `irq` in the cycle after the write.
- R7: Each frame is a 0 start bit, eight data bits LSB first, and a 1 stop bit. `txd` advances one bit per `baud_tick` pulse and idles at 1.
- R8: The line-quiet flag (status bit 6) is cleared by the clearing data write. It is set on the tick that ends a stop bit when the buffer is empty.
- R9: A status read that sees the empty flag at 0 cancels any armed state. Any data write uses up the armed state. A data write while the buffer is full is ignored, and the stored byte is the one that is sent.
- R10: Address 0 is control (bit 0 transmit enable, bit 1 interrupt enable), address 1 is status (read-only), and address 2 is data (reads as 0). Read data is combinational, so it is valid in the cycle `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| baud_tick | input | 1 | One-cycle pulse per serial bit time |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Transmit interrupt request |

## Verification
A write changes the empty flag and the line-quiet flag at the edge that takes it. The transfer into the shifter, with the flag back at 1 and the start bit on `txd`, comes one edge later. Each later bit appears at the edge after its `baud_tick`, and `irq` follows the flags in the same cycle. The bench keeps a behavioural model that advances on each rising edge and compares `txd` and `irq` with it at every falling edge. Register reads are sampled one nanosecond after the falling edge that raises `bus_rd`, which is before the edge that acts on them. A separate line decoder samples `txd` in every cycle that carries a tick and rebuilds the bytes to check frame order.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_TE_BIT  = 0;
    localparam int CTRL_TIE_BIT = 1;
endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              shift_idle,
    input  logic              frame_done,
    output logic              te,
    output logic              tie,
    output logic              empty,
    output logic              tc,
    output logic              armed,
    output logic [DATA_W-1:0] hold,
    output logic              load
);
    typedef struct packed {
        logic              te;
        logic              tie;
        logic              armed;
        logic              empty;
        logic              tc;
        logic [DATA_W-1:0] hold;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl, rd_stat, wr_data, clr_write;

    always_comb begin
        d         = q;
        wr_ctrl   = wr && (addr == REG_CTRL);
        rd_stat   = rd && (addr == REG_STAT);
        wr_data   = wr && (addr == REG_DATA);
        clr_write = wr_data && q.empty && q.armed;
        load      = q.te && !q.empty && shift_idle;

        if (wr_ctrl) begin
            d.te  = wdata[CTRL_TE_BIT];
            d.tie = wdata[CTRL_TIE_BIT];
        end
        if (rd_stat) begin
            d.armed = q.empty;
        end
        if (wr_data) begin
            d.armed = 1'b0;
            if (q.empty) begin
                d.hold = wdata;
            end
        end
        if (clr_write) begin
            d.empty = 1'b0;
        end
        if (load) begin
            d.empty = 1'b1;
        end
        if (frame_done && q.empty) begin
            d.tc = 1'b1;
        end
        if (clr_write) begin
            d.tc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{te: 1'b0, tie: 1'b0, armed: 1'b0, empty: 1'b1, tc: 1'b1,
                   hold: '0};
        end else begin
            q <= d;
        end
    end

    assign te    = q.te;
    assign tie   = q.tie;
    assign empty = q.empty;
    assign tc    = q.tc;
    assign armed = q.armed;
    assign hold  = q.hold;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              tick,
    output logic              idle,
    output logic              done,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
    } shift_t;

    shift_t q, d;

    always_comb begin
        d    = q;
        done = q.busy && tick && (q.cnt == LAST);
        if (load && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.sh   = {1'b1, data, 1'b0};
        end else if (q.busy && tick) begin
            if (done) begin
                d.busy = 1'b0;
            end else begin
                d.sh  = {1'b1, q.sh[FRAME_W-1:1]};
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, cnt: '0, sh: '1};
        end else begin
            q <= d;
        end
    end

    assign idle = !q.busy;
    assign txd  = q.busy ? q.sh[0] : 1'b1;
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              baud_tick,
    output logic              txd,
    output logic              irq
);
    localparam int PAD_W = DATA_W - 2;

    logic              te, tie, empty_flag, tc_flag, armed, load;
    logic              shift_idle, frame_done;
    logic [DATA_W-1:0] hold;

    uart_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .shift_idle (shift_idle),
        .frame_done (frame_done),
        .te         (te),
        .tie        (tie),
        .empty      (empty_flag),
        .tc         (tc_flag),
        .armed      (armed),
        .hold       (hold),
        .load       (load)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .data  (hold),
        .tick  (baud_tick),
        .idle  (shift_idle),
        .done  (frame_done),
        .txd   (txd)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                REG_CTRL: bus_rdata = {{PAD_W{1'b0}}, tie, te};
                REG_STAT: bus_rdata = {empty_flag, tc_flag, {PAD_W{1'b0}}};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = empty_flag && tie;
endmodule

// File: rtl/uart_tx_sva.sv
module uart_tx_sva
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              txd,
    input logic              te,
    input logic              empty,
    input logic              tc,
    input logic              armed,
    input logic              load,
    input logic              shift_idle,
    input logic [DATA_W-1:0] hold
);
    // R3: the flag only falls after an armed data write
    a_r3_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty) |-> $past(bus_wr && bus_addr == REG_DATA && armed));

    // R5: with the transmitter off, a full buffer stays full
    a_r5_hold_without_te: assert property (@(posedge clk) disable iff (!rst_n)
        (!te && !empty) |=> !empty);

    // R7: a transfer into the shifter puts the start bit on the line
    a_r7_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);

    // R8: line-quiet means shifter idle and buffer empty
    a_r8_tc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (shift_idle && empty));

    // R9: a data write into a full buffer leaves the stored byte alone
    a_r9_full_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA && !empty) |=> $stable(hold));
endmodule

bind uart_tx_dbuf uart_tx_sva #(.DATA_W(DATA_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .txd        (txd),
    .te         (te),
    .empty      (empty_flag),
    .tc         (tc_flag),
    .armed      (armed),
    .load       (load),
    .shift_idle (shift_idle),
    .hold       (hold)
);

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       baud_tick = 1'b0;
    logic       txd;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    uart_tx_dbuf dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .baud_tick (baud_tick),
        .txd       (txd),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    // baud pulse every fourth cycle
    int baud_cnt = 0;
    always @(negedge clk) begin
        baud_cnt  <= (baud_cnt == 3) ? 0 : baud_cnt + 1;
        baud_tick <= (baud_cnt == 3);
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_te = 0, m_tie = 0, m_arm = 0, m_empty = 1, m_tc = 1, m_busy = 0;
    int m_buf = 0;
    bit m_bits[$];

    always @(posedge clk) begin
        bit n_te, n_tie, n_arm, n_empty, n_tc, n_busy, clr, ld, fin;
        int n_buf;
        if (!rst_n) begin
            m_te = 0; m_tie = 0; m_arm = 0; m_empty = 1; m_tc = 1;
            m_busy = 0; m_buf = 0; m_bits.delete();
        end else begin
            n_te = m_te; n_tie = m_tie; n_arm = m_arm; n_empty = m_empty;
            n_tc = m_tc; n_busy = m_busy; n_buf = m_buf; fin = 0;
            clr = bus_wr && bus_addr == 2'd2 && m_empty && m_arm;
            ld  = m_te && !m_empty && !m_busy;
            if (bus_wr && bus_addr == 2'd0) begin
                n_te = bus_wdata[0]; n_tie = bus_wdata[1];
            end
            if (bus_rd && bus_addr == 2'd1) n_arm = m_empty;
            if (bus_wr && bus_addr == 2'd2) begin
                n_arm = 0;
                if (m_empty) n_buf = bus_wdata;
            end
            if (clr) n_empty = 0;
            if (m_busy && baud_tick) begin
                void'(m_bits.pop_front());
                if (m_bits.size() == 0) begin
                    n_busy = 0;
                    fin = 1;
                end
            end
            if (ld) begin
                m_bits.push_back(1'b0);
                for (int i = 0; i < 8; i++) m_bits.push_back(m_buf[i]);
                m_bits.push_back(1'b1);
                n_busy = 1; n_empty = 1;
            end
            if (fin && m_empty) n_tc = 1;
            if (clr) n_tc = 0;
            m_te = n_te; m_tie = n_tie; m_arm = n_arm; m_empty = n_empty;
            m_tc = n_tc; m_busy = n_busy; m_buf = n_buf;
        end
    end

    // per-cycle comparison of line and interrupt
    always @(negedge clk) begin
        if (rst_n) begin
            check("R7 txd vs model", int'(txd), m_busy ? int'(m_bits[0]) : 1);
            check("R6 irq vs model", int'(irq), int'(m_empty && m_tie));
        end
    end

    // line decoder: sample txd in each cycle that carries a tick
    int rxq[$];
    bit rx_on = 0;
    int rx_n = 0;
    logic [7:0] rx_val = 8'h00;
    always @(negedge clk) begin
        #1;
        if (rst_n && baud_tick) begin
            if (!rx_on) begin
                if (!txd) begin
                    rx_on = 1; rx_n = 0; rx_val = 8'h00;
                end
            end else if (rx_n < 8) begin
                rx_val[rx_n] = txd;
                rx_n++;
            end else begin
                check("R7 stop bit", int'(txd), 1);
                rxq.push_back(int'(rx_val));
                rx_on = 0;
            end
        end
    end

    // ---------------- bus tasks (start and end on a falling edge) ----------------
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata;
        if (a == 2'd1) check("R3/R8 status vs model", int'(v), (m_empty ? 8'h80 : 0) | (m_tc ? 8'h40 : 0));
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic wait_flag(input int bitpos);
        logic [7:0] v;
        do rd_reg(2'd1, v); while (!v[bitpos]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 txd idle", int'(txd), 1);
        check("R1 irq low", int'(irq), 0);
        rd_reg(2'd0, v); check("R1 ctrl reset", int'(v), 8'h00);
        rd_reg(2'd2, v); check("R10 data reads 0", int'(v), 8'h00);

        // R2: data write with no armed read
        wr_reg(2'd2, 8'h55);
        rd_reg(2'd1, v); check("R2 flag stays set", int'(v), 8'hC0);
        idle(20);

        // R3/R5: armed write with transmitter off
        wr_reg(2'd2, 8'h3C);
        rd_reg(2'd1, v); check("R3 flag cleared", int'(v), 8'h00);
        idle(40);
        rd_reg(2'd1, v); check("R5 byte held with TE off", int'(v), 8'h00);
        wr_reg(2'd2, 8'h77);
        wr_reg(2'd0, 8'h01);
        rd_reg(2'd1, v); check("R5 still full before transfer", int'(v), 8'h00);
        #1; check("R4 start bit with transfer", int'(txd), 0);
        rd_reg(2'd1, v); check("R4 flag back to 1", int'(v), 8'h80);
        while (rxq.size() < 1) @(negedge clk);
        check("R7 R9 first frame byte", rxq[0], 8'h3C);
        wait_flag(6);
        rd_reg(2'd1, v); check("R8 line quiet", int'(v), 8'hC0);

        // R6/R4: back-to-back with interrupts
        wr_reg(2'd0, 8'h03);
        #1; check("R6 irq with flag and enable", int'(irq), 1);
        wr_reg(2'd2, 8'h81);
        #1; check("R6 irq drops with flag", int'(irq), 0);
        rd_reg(2'd1, v); check("R8 quiet cleared by write", int'(v), 8'h00);
        rd_reg(2'd1, v); check("R4 fall-through", int'(v), 8'h80);
        wr_reg(2'd2, 8'h42);
        rd_reg(2'd1, v); check("R3 buffer full behind shifter", int'(v), 8'h00);
        wait_flag(7);
        wr_reg(2'd0, 8'h01);
        #1; check("R6 irq off after enable cleared", int'(irq), 0);
        wait_flag(6);
        check("R7 frame count", rxq.size(), 3);
        check("R7 second byte", rxq[1], 8'h81);
        check("R7 third byte", rxq[2], 8'h42);

        // R9: arm cancelled by a read that sees 0
        wr_reg(2'd0, 8'h00);
        rd_reg(2'd1, v);
        wr_reg(2'd2, 8'h11);
        rd_reg(2'd1, v); check("R9 full after armed write", int'(v), 8'h00);
        wr_reg(2'd0, 8'h01);
        idle(2);
        wr_reg(2'd2, 8'h22);
        rd_reg(2'd1, v); check("R9 cancelled arm keeps flag", int'(v), 8'h80);
        wait_flag(6);
        idle(50);
        check("R9 only one more frame", rxq.size(), 4);
        check("R9 held byte sent", rxq[3], 8'h11);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule